// File: doc/BRIEF.md
# Display Page Buffer Address Generator

This block produces the logical addresses of every byte of one displayed page of character rows held in external memory. A page is a stack of row buffers. Each row buffer is two or three 40-byte buffers that share one district and one row code (Y). The buffers of a row buffer sit on consecutive block numbers, counted modulo 4. Consecutive row buffers sit on consecutive row codes. The district is fixed for the whole page.

A fetch engine loads a page descriptor and pulses `start`. The descriptor holds the district, an even starting block, a starting row code and a two/three buffer format flag. The block then offers one address per byte on a valid/ready stream, and the consumer takes each one by holding `addr_ready` high.

Back-pressure rules for the stream:
- While `addr_valid` is high and `addr_ready` is low, every address field holds its value.
- An address is consumed only on a clock edge where both `addr_valid` and `addr_ready` are high.
- The consumer may hold `addr_ready` low for any number of cycles.

Two one-cycle pulses mark progress: `row_done` after the last byte of each row, and `page_done` after the last row.

Top module: `page_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `row_done`, `page_done` and `err` are all low.
- R2: A `start` pulse with a legal descriptor makes `addr_valid` high on the next cycle. The first address is X=0, the descriptor's block, the descriptor's row code, and the descriptor's district.
- R3: Each accepted address advances X by one, from 0 to COLS-1. After COLS-1, X returns to 0.
- R4: When X wraps, the block number advances by one modulo 4 (3 is followed by 0). A row holds 2 buffers when `cfg_three` is 0 and 3 buffers when it is 1.
- R5: After the last byte of the last buffer of a row, the block returns to the starting block and the row code steps. Row codes 8..30 step up by one, 31 wraps to 8, 0 steps to 1, and 1 steps to 8.
- R6: The district output equals the descriptor district for the whole page.
- R7: `row_done` is high for exactly the one cycle after the last byte of each row is accepted.
- R8: After ROWS rows, `page_done` pulses for one cycle and `addr_valid` goes low in that same cycle.
- R9: A `start` is refused when the starting block is odd or the row code is 2..7. A refused start sets `err` high and leaves `addr_valid` low. `err` stays high until the next start is accepted; an accepted start clears it.
- R10: While `addr_valid` is high and `addr_ready` is low, X, block, Y and district hold their values.
- R11: A `start` that arrives while a page is in progress has no effect. The address sequence continues as if it had not arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page using the descriptor inputs |
| cfg_district | input | 4 | District of the page |
| cfg_block | input | 2 | First block of each row buffer (must be even) |
| cfg_row | input | 5 | Starting row code |
| cfg_three | input | 1 | 1: three buffers per row, 0: two |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_district | output | 4 | District field |
| addr_block | output | 2 | Block field |
| addr_row | output | 5 | Row code field |
| addr_col | output | $clog2(COLS) | Column field X |
| row_done | output | 1 | Pulse after the last byte of a row |
| page_done | output | 1 | Pulse after the last row of a page |
| err | output | 1 | Last start was refused |

## Verification
The bench builds the block with COLS=4 and keeps ROWS at its default of 25. Short buffers make a full 25-row page only a few hundred bytes long. Full pages therefore fit easily into a run, including three-buffer pages that cross the 31-to-8 row wrap and pages that start from codes 0 and 1. Keeping ROWS at 25 exercises the real page-length boundary and the timing of `page_done`.

// File: rtl/page_addr_pkg.sv
package page_addr_pkg;
  typedef logic [3:0] district_t;
  typedef logic [1:0] block_t;
  typedef logic [4:0] yrow_t;

  localparam yrow_t RING_FIRST = 5'd8;
  localparam yrow_t RING_LAST  = 5'd31;

  function automatic logic row_code_ok(input yrow_t y);
    return (y < 5'd2) || (y >= RING_FIRST);
  endfunction

  function automatic yrow_t row_code_next(input yrow_t y);
    yrow_t n;
    if (y == RING_LAST || y == 5'd1) n = RING_FIRST;
    else                             n = y + 5'd1;
    return n;
  endfunction
endpackage

// File: rtl/pag_col_ctr.sv
module pag_col_ctr #(
  parameter int COLS = 40,
  localparam int XW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [XW-1:0] x,
  output logic          last
);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);

  assign last = (x == XMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)      x <= '0;
    else if (clear)  x <= '0;
    else if (step)   x <= last ? '0 : x + 1'b1;
  end

  a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n) x <= XMAX);
  a_r3_col_wrap:  assert property (@(posedge clk) disable iff (!rst_n)
                    (step && !clear && last) |=> (x == '0));
endmodule

// File: rtl/pag_blk_ctr.sv
module pag_blk_ctr
  import page_addr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  block_t base_in,
  input  logic   three_in,
  input  logic   step,
  output block_t blk,
  output logic   last_buf
);
  block_t     base_q;
  logic       three_q;
  logic [1:0] idx;

  assign last_buf = (idx == (three_q ? 2'd2 : 2'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; three_q <= 1'b0; idx <= '0; blk <= '0;
    end else if (load) begin
      base_q <= base_in; three_q <= three_in; idx <= '0; blk <= base_in;
    end else if (step) begin
      if (last_buf) begin
        idx <= '0; blk <= base_q;
      end else begin
        idx <= idx + 2'd1; blk <= blk + 2'd1;
      end
    end
  end

  a_r4_blk_mod4: assert property (@(posedge clk) disable iff (!rst_n)
                   (step && !load && !last_buf) |=> (blk == $past(blk) + 2'd1));
  a_r5_blk_back: assert property (@(posedge clk) disable iff (!rst_n)
                   (step && !load && last_buf) |=> (blk == base_q));
endmodule

// File: rtl/pag_row_ctr.sv
module pag_row_ctr
  import page_addr_pkg::*;
#(
  parameter int ROWS = 25,
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  yrow_t y_in,
  input  logic  step,
  output yrow_t y,
  output logic  last_row
);
  logic [RW-1:0] ridx;

  assign last_row = (ridx == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y <= '0; ridx <= '0;
    end else if (load) begin
      y <= y_in; ridx <= '0;
    end else if (step) begin
      y <= row_code_next(y);
      ridx <= last_row ? '0 : ridx + 1'b1;
    end
  end

  a_r5_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                    (step && !load && y == RING_LAST) |=> (y == RING_FIRST));
  a_r5_ring_up:   assert property (@(posedge clk) disable iff (!rst_n)
                    (step && !load && y >= RING_FIRST && y != RING_LAST) |=> (y == $past(y) + 5'd1));
endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen
  import page_addr_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 25,
  localparam int XW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    cfg_district,
  input  logic [1:0]    cfg_block,
  input  logic [4:0]    cfg_row,
  input  logic          cfg_three,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [3:0]    addr_district,
  output logic [1:0]    addr_block,
  output logic [4:0]    addr_row,
  output logic [XW-1:0] addr_col,
  output logic          row_done,
  output logic          page_done,
  output logic          err
);
  logic busy, fire, x_last, buf_last, row_last;
  logic desc_ok, start_ok, blk_step, row_step, page_end;
  district_t dist_q;

  assign desc_ok  = !cfg_block[0] && row_code_ok(cfg_row);
  assign start_ok = start && !busy && desc_ok;
  assign fire     = busy && addr_ready;
  assign blk_step = fire && x_last;
  assign row_step = blk_step && buf_last;
  assign page_end = row_step && row_last;

  pag_col_ctr #(.COLS(COLS)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .step(fire),
    .x(addr_col), .last(x_last));

  pag_blk_ctr u_blk (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .base_in(cfg_block),
    .three_in(cfg_three), .step(blk_step), .blk(addr_block), .last_buf(buf_last));

  pag_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .y_in(cfg_row),
    .step(row_step), .y(addr_row), .last_row(row_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; dist_q <= '0;
      row_done <= 1'b0; page_done <= 1'b0;
    end else begin
      row_done  <= row_step;
      page_done <= page_end;
      if (start && !busy) err <= !desc_ok;
      if (start_ok) begin
        busy <= 1'b1; dist_q <= cfg_district;
      end else if (page_end) begin
        busy <= 1'b0;
      end
    end
  end

  assign addr_valid    = busy;
  assign addr_district = dist_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_valid && !addr_ready) |=>
                ($stable(addr_col) && $stable(addr_block) && $stable(addr_row) && $stable(addr_district)));
  a_r6_district: assert property (@(posedge clk) disable iff (!rst_n)
                   (addr_valid && $past(addr_valid)) |-> $stable(addr_district));
  a_r5_legal_row: assert property (@(posedge clk) disable iff (!rst_n)
                    addr_valid |-> row_code_ok(addr_row));
  a_r8_page_end: assert property (@(posedge clk) disable iff (!rst_n)
                   page_done |-> !addr_valid);
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
                   err |-> !addr_valid);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                row_done |=> !row_done || $past(addr_valid));
endmodule

// File: tb/page_addr_gen_test.sv
module page_addr_gen_test;
  localparam int COLS = 4;
  localparam int ROWS = 25;
  localparam int XW = $clog2(COLS);
  localparam int NV = 8;
  // {district, block, row, three, expect_refusal}
  localparam logic [12:0] VEC [NV] = '{
    {4'd5,  2'd0, 5'd8,  1'b0, 1'b0},
    {4'd9,  2'd2, 5'd30, 1'b1, 1'b0},
    {4'd3,  2'd1, 5'd10, 1'b0, 1'b1},
    {4'd15, 2'd2, 5'd0,  1'b1, 1'b0},
    {4'd0,  2'd0, 5'd5,  1'b1, 1'b1},
    {4'd7,  2'd0, 5'd1,  1'b0, 1'b0},
    {4'd12, 2'd2, 5'd31, 1'b0, 1'b0},
    {4'd1,  2'd2, 5'd2,  1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, addr_ready = 1'b0;
  logic [3:0] cfg_district = '0; logic [1:0] cfg_block = '0;
  logic [4:0] cfg_row = '0; logic cfg_three = 1'b0;
  logic addr_valid, row_done, page_done, err;
  logic [3:0] addr_district; logic [1:0] addr_block; logic [4:0] addr_row;
  logic [XW-1:0] addr_col;
  int checks = 0, errors = 0;
  logic [7:0] lfsr = 8'h5a;

  always #5 clk = ~clk;

  page_addr_gen #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_district(cfg_district),
    .cfg_block(cfg_block), .cfg_row(cfg_row), .cfg_three(cfg_three),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_district(addr_district),
    .addr_block(addr_block), .addr_row(addr_row), .addr_col(addr_col),
    .row_done(row_done), .page_done(page_done), .err(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step_row(input int y);
    case (y)
      31, 1:   return 8;
      default: return y + 1;
    endcase
  endfunction

  task automatic run_page(input logic [12:0] v, input bit stall, input bit restart);
    int ex, eb, ey, nbuf, bufs, rows, bytes;
    bit exp_rd, exp_pd, done;
    @(negedge clk);
    {cfg_district, cfg_block, cfg_row, cfg_three} = v[12:1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 err", err, v[0]);
    if (v[0]) begin
      chk("R9 refused start no valid", addr_valid, 0);
      repeat (3) @(negedge clk);
      chk("R9 still idle", addr_valid, 0);
      return;
    end
    ex = 0; eb = v[7:6]; ey = v[5:1]; nbuf = v[1] ? 3 : 2;
    ey = v[6:2];
    eb = v[8:7];
    nbuf = v[1] ? 3 : 2;
    bufs = 0; rows = 0; bytes = 0; exp_rd = 0; exp_pd = 0; done = 0;
    while (!done) begin
      chk("R7 row_done", row_done, exp_rd);
      chk("R8 page_done", page_done, exp_pd);
      if (rows == ROWS) begin
        chk("R8 valid drops", addr_valid, 0);
        done = 1;
      end else begin
        chk("R2 valid", addr_valid, 1);
        chk("R3 col", addr_col, ex);
        chk("R4 block", addr_block, eb);
        chk("R5 row", addr_row, ey);
        chk("R6 district", addr_district, v[12:9]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        addr_ready = stall ? lfsr[0] : 1'b1;
        if (restart && bytes == 10) begin
          start = 1'b1; cfg_district = ~v[12:9]; cfg_row = 5'd20; cfg_block = 2'd0;
        end else start = 1'b0;
        exp_rd = 0; exp_pd = 0;
        if (addr_ready) begin
          bytes++;
          if (ex == COLS - 1) begin
            ex = 0;
            if (bufs == nbuf - 1) begin
              bufs = 0; eb = v[8:7]; ey = step_row(ey); rows++; exp_rd = 1;
              if (rows == ROWS) exp_pd = 1;
            end else begin
              bufs++; eb = (eb + 1) % 4;
            end
          end else ex++;
        end
      end
      @(negedge clk);
    end
    start = 1'b0; addr_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", addr_valid, 0);
    chk("R1 row_done", row_done, 0);
    chk("R1 page_done", page_done, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_page(VEC[i], (i % 2) == 1, i == 1);
    // R11 restart during page plus R9 err cleared by a good start after refusal
    run_page({4'd2, 2'd1, 5'd9, 1'b0, 1'b1}, 1'b0, 1'b0);
    run_page({4'd6, 2'd2, 5'd29, 1'b1, 1'b0}, 1'b1, 1'b1);
    chk("R9 err cleared", err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule